// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the serial slave front end of a 256-byte two-wire EEPROM. A system clock samples the bus clock and data lines through two-flop synchronizers. The block finds start and stop conditions on the synchronized lines and shifts in a device header, a word address and data bytes. It answers each accepted byte with an acknowledge and sends read data through an output enable that can only pull SDA low. It also holds the internal address counter that current-address, random and sequential reads use.

Each write data byte goes out to the page write controller as a one-cycle strobe with its address and value. A stop after at least one data byte sends a commit pulse, which starts the self-timed programming cycle. The controller raises `busy` during that cycle, and while `busy` is high the engine does not acknowledge its header, so a master can poll for completion. Read bytes come from the array through a combinational port (`rd_addr` out, `rd_data` in).

The control is one state machine with ten states:
- `S_IDLE`: waiting for a start.
- `S_DEV`: receiving the header.
- `S_DEV_ACK`: acknowledging the header.
- `S_WADDR` and `S_WADDR_ACK`: receiving and acknowledging the word address.
- `S_WDATA` and `S_WDATA_ACK`: receiving and acknowledging a data byte.
- `S_RDATA`: sending a read byte.
- `S_RACK`: waiting for the master's acknowledge.
- `S_IGNORE`: parked until the next start or stop.

A start moves any state to `S_DEV`, and a stop moves any state to `S_IDLE`. On the eighth bit, `S_DEV` goes to `S_DEV_ACK` on a match and to `S_IGNORE` otherwise. `S_DEV_ACK` then goes to `S_RDATA` for a read or to `S_WADDR` for a write. Each receive state goes to its acknowledge state on the eighth rising edge, and each acknowledge state returns to the data phase when the ninth clock falls. In `S_RACK`, a master acknowledge leads back to `S_RDATA` and a non-acknowledge leads to `S_IGNORE`.

Top module: `eeslv_engine`

## Requirements
- R1: A start (SDA falls while SCL is high) begins header reception from any state and releases SDA. A stop (SDA rises while SCL is high) returns the engine to idle with SDA released.
- R2: Incoming bits are taken on SCL rising edges, most significant bit first.
- R3: The header is accepted only when bits 7..4 are 1010 and bits 3..1 equal `chip_sel`. Bit 0 selects the direction (1 = read, 0 = write). A rejected header gets no acknowledge, and every later byte is ignored (no acknowledge, no strobe) until the next start.
- R4: After each accepted byte, SDA is pulled low from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock.
- R5: While `busy` is high, a matching header is not acknowledged. Once `busy` is low, the same header is acknowledged.
- R6: The word address of a write loads the address counter. Each data byte produces one `wr_strobe` carrying the current counter and the byte. Only the low four counter bits then increment, wrapping inside the 16-byte page, so the 17th byte lands on the first byte's address.
- R7: A stop after at least one write data byte pulses `wr_commit` once. A stop after a header plus word address only, after a read, or after a rejected header does not.
- R8: A read sends the byte at the counter, MSB first, and then increments the counter. A master acknowledge requests the next byte, and a non-acknowledge ends the read. A current-address read continues from the last written or read address plus one.
- R9: During reads the counter wraps from 255 to 0.
- R10: A write header plus word address, followed by a repeated start and a read header, returns the data at that word address.
- R11: The SDA enable changes only while SCL is low.
- R12: After reset, SDA is released, the address counter is 0 and no strobe or commit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_sel | input | 3 | Strap value compared with header bits 3..1 |
| busy | input | 1 | Self-timed programming in progress |
| rd_addr | output | 8 | Address counter, the array read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_strobe | output | 1 | One-cycle pulse per received write data byte |
| wr_addr | output | 8 | Address for the strobed byte |
| wr_data | output | 8 | Strobed write byte |
| wr_commit | output | 1 | One-cycle pulse starting the programming cycle |

## Verification
The assertions assume the master changes SDA only while SCL is low, apart from start and stop conditions. They also assume that each SCL level lasts longer than the synchronizer latency, and that `busy` rises only after a commit and never during a write transaction. The bench master holds each SCL phase for six system clocks. It never issues a start or stop while the engine is driving SDA. Its array model raises `busy` only for a fixed time after `wr_commit`. Random page writes, random reads and current-address reads are therefore always separated by acknowledge polling.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_IGNORE
    } slv_state_e;
endpackage

// File: rtl/eeslv_line_sync.sv
module eeslv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_prev;
    logic              sda_prev;

    // Idle bus level is high, so everything resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh[0] <= scl_in;
            sda_sh[0] <= sda_in;
            for (int i = 1; i < STAGES; i++) begin
                scl_sh[i] <= scl_sh[i-1];
                sda_sh[i] <= sda_sh[i-1];
            end
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eeslv_rx_shift.sv
module eeslv_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] rx_next
);
    logic [W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_q <= '0;
        else if (shift_en) rx_q <= rx_next;
    end

    // Value the register holds once the current bit is shifted in.
    assign rx_next = {rx_q[W-2:0], bit_in};
endmodule

// File: rtl/eeslv_addr_ctr.sv
module eeslv_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_seq,
    input  logic              inc_col,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [COL_W-1:0]  ONE_C = COL_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr <= '0;
        else if (load)    addr <= load_val;
        else if (inc_seq) addr <= addr + ONE_A;
        else if (inc_col) addr <= {addr[ADDR_W-1:COL_W], addr[COL_W-1:0] + ONE_C};
    end
endmodule

// File: rtl/eeslv_engine.sv
module eeslv_engine
    import eeslv_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          PAGE_COL_W  = 4,
    parameter int          SEL_W       = 3,
    parameter logic [3:0]  DEV_ID      = 4'b1010,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  chip_sel,
    input  logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    slv_state_e state, nxt_state;
    logic [CNT_W-1:0]  bit_cnt;
    logic              phase;
    logic              is_read;
    logic              wr_pending;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_next;
    logic              rx_state, last_bit, byte_end, dev_hit;
    logic              ctr_load, ctr_inc_seq, ctr_inc_col;
    logic [ADDR_W-1:0] addr_q;

    eeslv_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    assign rx_state = (state == S_DEV) || (state == S_WADDR) || (state == S_WDATA);
    assign last_bit = (bit_cnt == LAST_BIT);
    assign byte_end = scl_rise && last_bit;

    eeslv_rx_shift #(.W(BYTE_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .shift_en(scl_rise && rx_state),
        .bit_in(sda_lvl), .rx_next(rx_next)
    );

    assign dev_hit = (rx_next[BYTE_W-1 -: 4] == DEV_ID)
                  && (rx_next[SEL_W:1] == chip_sel) && !busy;

    assign ctr_load    = (state == S_WADDR) && byte_end;
    assign ctr_inc_col = (state == S_WDATA) && byte_end;
    assign ctr_inc_seq = scl_fall && phase &&
                         (((state == S_DEV_ACK) && is_read) || (state == S_RACK));

    eeslv_addr_ctr #(.ADDR_W(ADDR_W), .COL_W(PAGE_COL_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(rx_next[ADDR_W-1:0]),
        .inc_seq(ctr_inc_seq), .inc_col(ctr_inc_col), .addr(addr_q)
    );
    assign rd_addr = addr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt_state;
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        if (start_det) begin
            nxt_state = S_DEV;
        end else if (stop_det) begin
            nxt_state = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: nxt_state = state;
                S_DEV:       if (byte_end) nxt_state = dev_hit ? S_DEV_ACK : S_IGNORE;
                S_DEV_ACK:   if (scl_fall && phase) nxt_state = is_read ? S_RDATA : S_WADDR;
                S_WADDR:     if (byte_end) nxt_state = S_WADDR_ACK;
                S_WADDR_ACK: if (scl_fall && phase) nxt_state = S_WDATA;
                S_WDATA:     if (byte_end) nxt_state = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall && phase) nxt_state = S_WDATA;
                S_RDATA:     if (byte_end) nxt_state = S_RACK;
                S_RACK: begin
                    if (scl_rise && sda_lvl)    nxt_state = S_IGNORE;
                    else if (scl_fall && phase) nxt_state = S_RDATA;
                end
                default: nxt_state = S_IDLE;
            endcase
        end
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            phase      <= 1'b0;
            sda_oe     <= 1'b0;
            tx_q       <= '0;
            is_read    <= 1'b0;
            wr_pending <= 1'b0;
            wr_strobe  <= 1'b0;
            wr_commit  <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_strobe <= 1'b0;
            wr_commit <= 1'b0;
            if (start_det) begin
                bit_cnt    <= '0;
                phase      <= 1'b0;
                sda_oe     <= 1'b0;
                wr_pending <= 1'b0;
            end else if (stop_det) begin
                bit_cnt    <= '0;
                phase      <= 1'b0;
                sda_oe     <= 1'b0;
                wr_commit  <= wr_pending;
                wr_pending <= 1'b0;
            end else begin
                unique case (state)
                    S_DEV, S_WADDR, S_WDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + ONE_CNT;
                            if (last_bit) begin
                                phase <= 1'b0;
                                if (state == S_DEV) is_read <= rx_next[0];
                                if (state == S_WDATA) begin
                                    wr_strobe  <= 1'b1;
                                    wr_addr    <= addr_q;
                                    wr_data    <= rx_next;
                                    wr_pending <= 1'b1;
                                end
                            end
                        end
                    end
                    S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: begin
                        if (scl_fall) begin
                            if (!phase) begin
                                sda_oe <= 1'b1;
                                phase  <= 1'b1;
                            end else begin
                                phase   <= 1'b0;
                                bit_cnt <= '0;
                                if ((state == S_DEV_ACK) && is_read) begin
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                    tx_q   <= {rd_data[BYTE_W-2:0], 1'b0};
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise) bit_cnt <= bit_cnt + ONE_CNT;
                        if (scl_fall) begin
                            sda_oe <= ~tx_q[BYTE_W-1];
                            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    S_RACK: begin
                        if (scl_fall) begin
                            if (!phase) begin
                                sda_oe <= 1'b0;
                                phase  <= 1'b1;
                            end else begin
                                phase   <= 1'b0;
                                bit_cnt <= '0;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                tx_q    <= {rd_data[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eeslv_checker.sv
module eeslv_checker #(
    parameter int ADDR_W = 8,
    parameter int COL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              busy,
    input logic              wr_strobe,
    input logic              wr_commit,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr
);
    // R11
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);

    // R6
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (rd_addr[ADDR_W-1:COL_W] == wr_addr[ADDR_W-1:COL_W]) &&
                      (rd_addr[COL_W-1:0] == COL_W'(wr_addr[COL_W-1:0] + 1'b1)));

    // R5
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_strobe);

    // R7
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_det));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, wr_commit}));
endmodule

bind eeslv_engine eeslv_checker #(.ADDR_W(ADDR_W), .COL_W(PAGE_COL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .busy(busy), .wr_strobe(wr_strobe),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .rd_addr(rd_addr)
);

// File: tb/eeslv_engine_tb_top.sv
module eeslv_engine_tb_top;
    localparam int Q        = 6;
    localparam int BUSY_CYC = 300;
    localparam logic [2:0] MY_SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, busy, wr_strobe, wr_commit;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic sda_line;

    logic [7:0] mem [0:255];
    logic [7:0] exp_mem [0:255];
    logic [7:0] exp_ptr;
    logic [7:0] wbuf [0:19];
    int busy_cnt;
    int commits = 0;
    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign busy     = (busy_cnt != 0);
    assign rd_data  = mem[rd_addr];

    eeslv_engine dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .chip_sel(MY_SEL), .busy(busy), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit)
    );

    // Array and programming timer model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
            busy_cnt <= 0;
        end else begin
            if (wr_strobe) mem[wr_addr] <= wr_data;
            if (wr_commit) begin
                busy_cnt <= BUSY_CYC;
                commits  <= commits + 1;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    // SDA enable must not move while SCL is high (R11)
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) oe_viol++;
        prev_oe  <= sda_oe;
        prev_scl <= m_scl;
    end

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    function automatic logic [7:0] page_addr(input logic [7:0] a, input int i);
        return {a[7:4], 4'(a[3:0] + i[3:0])};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q / 2);
        ack = sda_line; wq(Q - Q / 2);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic more);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q);
            m_scl = 1'b1; wq(Q / 2);
            b[i] = sda_line; wq(Q - Q / 2);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = more ? 1'b0 : 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    // Page write of n bytes from wbuf; returns number of missing acks
    task automatic do_write(input logic [7:0] a, input int n, output int naks);
        logic ack;
        naks = 0;
        bus_start();
        send_byte(dev_byte(MY_SEL, 1'b0), ack); naks += ack;
        send_byte(a, ack); naks += ack;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); naks += ack;
            exp_mem[page_addr(a, i)] = wbuf[i];
        end
        bus_stop();
        exp_ptr = page_addr(a, n);
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            check(req, b, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string req);
        logic ack;
        int naks = 0;
        bus_start();
        send_byte(dev_byte(MY_SEL, 1'b0), ack); naks += ack;
        send_byte(a, ack); naks += ack;
        bus_start();
        send_byte(dev_byte(MY_SEL, 1'b1), ack); naks += ack;
        check({req, " header acks"}, naks, 0);
        exp_ptr = a;
        read_bytes(n, req);
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        bus_start();
        send_byte(dev_byte(MY_SEL, 1'b1), ack);
        check({req, " header ack"}, ack, 0);
        read_bytes(n, req);
    endtask

    // Poll until acknowledged; first poll must be refused when busy is known high
    task automatic poll_ready(input bit expect_busy);
        logic ack;
        int tries = 0;
        ack = 1'b1;
        while (ack && tries < 40) begin
            bus_start();
            send_byte(dev_byte(MY_SEL, 1'b0), ack);
            bus_stop();
            if (tries == 0 && expect_busy) check("R5 nak while busy", ack, 1);
            tries++;
        end
        check("R5 ack after busy ends", ack, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic ack;
        int naks, c0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);
        exp_ptr = 8'd0;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R12 reset state
        check("R12 sda_oe", sda_oe, 0);
        check("R12 rd_addr", rd_addr, 0);
        check("R12 wr_strobe", wr_strobe, 0);

        // R8 current read straight after reset starts at 0
        cur_read(2, "R8 read from reset pointer");

        // R3 wrong chip select and wrong prefix: no acks, later bytes ignored
        c0 = commits;
        bus_start();
        send_byte(dev_byte(3'b010, 1'b0), ack);
        check("R3 sel mismatch nak", ack, 1);
        send_byte(8'h20, ack);
        check("R3 ignored byte nak", ack, 1);
        send_byte(8'h77, ack);
        check("R3 ignored data nak", ack, 1);
        bus_stop();
        bus_start();
        send_byte({4'b1011, MY_SEL, 1'b0}, ack);
        check("R3 prefix mismatch nak", ack, 1);
        bus_stop();
        check("R7 no commit after rejected header", commits, c0);

        // R2/R4 byte write, then R5 polling
        wbuf[0] = 8'hA5;
        do_write(8'h10, 1, naks);
        check("R4 acks on byte write", naks, 0);
        check("R7 one commit", commits, c0 + 1);
        poll_ready(1);
        rand_read(8'h10, 1, "R2 R10 byte write readback");

        // R6 page rollover: 20 bytes from 0x3E
        for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'hC0 + i);
        do_write(8'h3E, 20, naks);
        check("R6 acks on long page write", naks, 0);
        poll_ready(1);
        rand_read(8'h30, 16, "R6 page contents");
        // pointer after readback is 0x40; check write-then-current-read continuity
        wbuf[0] = 8'h5A;
        do_write(8'h77, 1, naks);
        poll_ready(1);
        cur_read(2, "R8 current read after write");

        // R9 sequential wrap
        rand_read(8'hFE, 4, "R9 wrap 255 to 0");

        // R7/R10 dummy write then stop: no commit, pointer loaded
        c0 = commits;
        bus_start();
        send_byte(dev_byte(MY_SEL, 1'b0), ack);
        send_byte(8'h55, ack);
        bus_stop();
        wq(4 * Q);
        check("R7 no commit after dummy write", commits, c0);
        check("R10 pointer loaded", rd_addr, 8'h55);
        exp_ptr = 8'h55;
        cur_read(1, "R10 current read after dummy write");

        // R1 start aborts a half-sent header
        bus_start();
        for (int i = 7; i >= 4; i--) begin
            m_sda = dev_byte(MY_SEL, 1'b0)[i]; wq(Q);
            m_scl = 1'b1; wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        rand_read(8'h3F, 2, "R1 restart after aborted byte");

        // Random mix
        for (int t = 0; t < 14; t++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 18);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(a, n, naks);
            check("R4 R6 random write acks", naks, 0);
            poll_ready(1);
            rand_read(8'($urandom), 1 + int'($urandom % 5), "R8 R10 random read");
            cur_read(1 + int'($urandom % 3), "R8 random current read");
        end

        check("R11 sda_oe steady while SCL high", oe_viol, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule